// File: doc/BRIEF.md
# Two-Wire Current Level Classifier

This block sits in a controller on the receiving end of a two-wire current-loop switch sensor. The sensor's supply current is turned into a voltage by a sense resistor and digitised by an ADC. Each converted code arrives on a single-cycle valid strobe. The block sorts every code into one of six classes, using programmable current windows: valid high, valid low, short, open, general fault and sensor self-reported fault.

A sensor that has found an internal fault draws a low base current with a brief current pulse in each long retry period. Sample by sample this looks like an open line broken up by stray pulses. The block therefore sums the codes over a tumbling block of 2^k samples. If the block mean lands in a programmable fault band, the result marks the following block as a sensor fault.

Valid levels become a logic bit. Two inversion controls set the mapping: one for a supply-side sense resistor and one for a sensor variant whose output sense is reversed. A persistence filter stops slew transients from reaching the reported class. A one-cycle strobe flags every reported change.

Top module: `twc_level_classifier`

## Requirements
- R1: A sample code strictly greater than `lim_hi_max` is classified as short (class code 2).
- R2: A code in `lim_hi_min`..`lim_hi_max` inclusive is valid high (class code 1). A code in `lim_lo_min`..`lim_lo_max` inclusive is valid low (class code 0). This holds when neither R1 nor R5 applies.
- R3: A code strictly between `lim_lo_max` and `lim_hi_min` is a general fault (class code 4), unless R5 applies.
- R4: A code strictly below `lim_lo_min` is open (class code 3), unless R5 applies.
- R5: Samples are grouped into consecutive blocks of 2^`avg_log2` samples. If the floor of a block's mean lies in `band_min`..`band_max` inclusive, the fault verdict is set for every sample of the next block; otherwise it is cleared. While the verdict is set, any code below `lim_hi_min` is classified as sensor fault (class code 5). `avg_log2` = 0 makes each sample its own block.
- R6: After a sample whose committed class is valid high or valid low, `logic_state` equals (class is valid high) XOR `rsense_high` XOR `variant_inv`. For any other committed class, `logic_state` keeps its previous value.
- R7: The reported class changes to a new class only once that class has been the raw result of `persist_n` consecutive samples. A `persist_n` of 0 acts as 1. The run counter saturates at its maximum.
- R8: `chg_stb` is high for exactly the one cycle after the clock edge that takes a sample which changes `cls_code` or `logic_state`. It is low at all other times.
- R9: After reset, `cls_code` is 3 (open), `logic_state` is 0, `chg_stb` is 0 and the fault verdict is clear.
- R10: In cycles without `smp_valid`, `cls_code`, `logic_state` and the averaging state do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_valid | input | 1 | Sample strobe, one cycle per ADC code |
| smp_code | input | CODE_W | ADC current code |
| lim_lo_min | input | CODE_W | Lower edge of the valid-low window |
| lim_lo_max | input | CODE_W | Upper edge of the valid-low window |
| lim_hi_min | input | CODE_W | Lower edge of the valid-high window |
| lim_hi_max | input | CODE_W | Upper edge of the valid-high window |
| band_min | input | CODE_W | Lower edge of the averaged sensor-fault band |
| band_max | input | CODE_W | Upper edge of the averaged sensor-fault band |
| avg_log2 | input | SH_W | Base-2 log of the averaging block length |
| persist_n | input | PERSIST_W | Consecutive samples needed to commit a class |
| rsense_high | input | 1 | Sense resistor on the supply side (inverts logic) |
| variant_inv | input | 1 | Sensor variant with reversed output sense |
| cls_code | output | 3 | Committed class code |
| logic_state | output | 1 | Mapped logic level |
| chg_stb | output | 1 | One-cycle change strobe |

## Verification
The hardest condition to reach from the ports is the sensor-fault class while a sample would on its own read as valid low or open. This requires a whole block of samples whose mean falls inside the fault band. The bench builds that signature directly: repeating periods of a low base code with one pulse code each, with a block length equal to the period. It then checks that the pulse samples are absorbed into the fault class rather than read as valid low. It then lowers the base so the mean drops out of the band and checks that the verdict clears at the next block boundary. An arithmetic reference model, run over a full ascending code sweep for each polarity setting, catches off-by-one edges of every window.

// File: rtl/twc_pkg.sv
package twc_pkg;
  typedef enum logic [2:0] {
    CLS_LOW   = 3'd0,
    CLS_HIGH  = 3'd1,
    CLS_SHORT = 3'd2,
    CLS_OPEN  = 3'd3,
    CLS_GEN   = 3'd4,
    CLS_SENS  = 3'd5
  } cls_e;
endpackage

// File: rtl/twc_window_cmp.sv
// Per-sample window decision; the averaged verdict overrides low readings.
module twc_window_cmp
  import twc_pkg::*;
#(
  parameter int CODE_W = 12
) (
  input  logic [CODE_W-1:0] code,
  input  logic [CODE_W-1:0] lo_min,
  input  logic [CODE_W-1:0] lo_max,
  input  logic [CODE_W-1:0] hi_min,
  input  logic [CODE_W-1:0] hi_max,
  input  logic              fault_avg,
  output cls_e              raw
);
  always_comb begin
    if (code > hi_max)        raw = CLS_SHORT;  // R1
    else if (code >= hi_min)  raw = CLS_HIGH;   // R2
    else if (fault_avg)       raw = CLS_SENS;   // R5
    else if (code > lo_max)   raw = CLS_GEN;    // R3
    else if (code >= lo_min)  raw = CLS_LOW;    // R2
    else                      raw = CLS_OPEN;   // R4
  end
endmodule

// File: rtl/twc_fault_avg.sv
// Tumbling-block sum; the block mean is tested against the fault band.
module twc_fault_avg #(
  parameter int CODE_W       = 12,
  parameter int MAX_AVG_LOG2 = 12,
  localparam int SUM_W       = CODE_W + MAX_AVG_LOG2,
  localparam int CNT_W       = (MAX_AVG_LOG2 < 1) ? 1 : MAX_AVG_LOG2,
  localparam int SH_W        = $clog2(MAX_AVG_LOG2 + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_valid,
  input  logic [CODE_W-1:0] code,
  input  logic [SH_W-1:0]   avg_log2,
  input  logic [CODE_W-1:0] band_min,
  input  logic [CODE_W-1:0] band_max,
  output logic              in_band
);
  logic [SUM_W-1:0] acc_q, acc_d, sum_nx, mean;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W:0]   lim;
  logic [SH_W-1:0]  sh;
  logic             band_q, band_d, last;

  always_comb begin
    sh     = (avg_log2 > SH_W'(MAX_AVG_LOG2)) ? SH_W'(MAX_AVG_LOG2) : avg_log2;
    lim    = ((CNT_W+1)'(1) << sh) - (CNT_W+1)'(1);
    last   = (cnt_q == lim[CNT_W-1:0]);
    sum_nx = acc_q + SUM_W'(code);
    mean   = sum_nx >> sh;
    acc_d  = acc_q;
    cnt_d  = cnt_q;
    band_d = band_q;
    if (smp_valid) begin
      if (last) begin
        band_d = (mean >= SUM_W'(band_min)) && (mean <= SUM_W'(band_max));
        acc_d  = '0;
        cnt_d  = '0;
      end else begin
        acc_d  = sum_nx;
        cnt_d  = cnt_q + CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      cnt_q  <= '0;
      band_q <= 1'b0;
    end else if (smp_valid) begin
      acc_q  <= acc_d;
      cnt_q  <= cnt_d;
      band_q <= band_d;
    end
  end

  assign in_band = band_q;

  a_r5_verdict_on_sample: assert property (@(posedge clk) disable iff (!rst_n)
    (band_q != $past(band_q)) |-> $past(smp_valid));
  a_r10_acc_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_valid |=> $stable(acc_q) && $stable(cnt_q));
endmodule

// File: rtl/twc_persist.sv
// Persistence filter, logic mapping and change strobe.
module twc_persist
  import twc_pkg::*;
#(
  parameter int PERSIST_W = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 smp_valid,
  input  cls_e                 raw,
  input  logic [PERSIST_W-1:0] persist_n,
  input  logic                 rsense_high,
  input  logic                 variant_inv,
  output cls_e                 cls_out,
  output logic                 state_out,
  output logic                 stb_out
);
  localparam logic [PERSIST_W-1:0] RUN_MAX = '1;

  cls_e                 pend_q, cls_q, cls_nx;
  logic [PERSIST_W-1:0] run_q, run_nx, need;
  logic                 state_q, state_nx, stb_q, stb_d, commit;

  always_comb begin
    need   = (persist_n == '0) ? PERSIST_W'(1) : persist_n;
    if (raw == pend_q) run_nx = (run_q == RUN_MAX) ? run_q : run_q + PERSIST_W'(1);
    else               run_nx = PERSIST_W'(1);
    commit = (run_nx >= need);
    cls_nx = commit ? raw : cls_q;
    case (cls_nx)
      CLS_HIGH: state_nx = 1'b1 ^ rsense_high ^ variant_inv;
      CLS_LOW:  state_nx = 1'b0 ^ rsense_high ^ variant_inv;
      default:  state_nx = state_q;
    endcase
    stb_d = smp_valid && ((cls_nx != cls_q) || (state_nx != state_q));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q  <= CLS_OPEN;
      run_q   <= '0;
      cls_q   <= CLS_OPEN;
      state_q <= 1'b0;
    end else if (smp_valid) begin
      pend_q  <= raw;
      run_q   <= run_nx;
      cls_q   <= cls_nx;
      state_q <= state_nx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stb_q <= 1'b0;
    else        stb_q <= stb_d;
  end

  assign cls_out   = cls_q;
  assign state_out = state_q;
  assign stb_out   = stb_q;

  a_r10_hold_class: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_valid |=> $stable(cls_q) && $stable(state_q));
  a_r8_stb_after_sample: assert property (@(posedge clk) disable iff (!rst_n)
    stb_q |-> $past(smp_valid));
  a_r8_change_flags: assert property (@(posedge clk) disable iff (!rst_n)
    ((cls_q != $past(cls_q)) || (state_q != $past(state_q))) |-> stb_q);
  a_r7_commit_run: assert property (@(posedge clk) disable iff (!rst_n)
    (cls_q != $past(cls_q)) |-> (run_q >= $past(need)) && (pend_q == cls_q));
endmodule

// File: rtl/twc_level_classifier.sv
module twc_level_classifier
  import twc_pkg::*;
#(
  parameter int CODE_W       = 12,
  parameter int PERSIST_W    = 4,
  parameter int MAX_AVG_LOG2 = 12,
  localparam int SH_W        = $clog2(MAX_AVG_LOG2 + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 smp_valid,
  input  logic [CODE_W-1:0]    smp_code,
  input  logic [CODE_W-1:0]    lim_lo_min,
  input  logic [CODE_W-1:0]    lim_lo_max,
  input  logic [CODE_W-1:0]    lim_hi_min,
  input  logic [CODE_W-1:0]    lim_hi_max,
  input  logic [CODE_W-1:0]    band_min,
  input  logic [CODE_W-1:0]    band_max,
  input  logic [SH_W-1:0]      avg_log2,
  input  logic [PERSIST_W-1:0] persist_n,
  input  logic                 rsense_high,
  input  logic                 variant_inv,
  output logic [2:0]           cls_code,
  output logic                 logic_state,
  output logic                 chg_stb
);
  cls_e raw, cls_c;
  logic fault_avg;

  twc_fault_avg #(.CODE_W(CODE_W), .MAX_AVG_LOG2(MAX_AVG_LOG2)) u_avg (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .code(smp_code),
    .avg_log2(avg_log2), .band_min(band_min), .band_max(band_max),
    .in_band(fault_avg)
  );

  twc_window_cmp #(.CODE_W(CODE_W)) u_cmp (
    .code(smp_code), .lo_min(lim_lo_min), .lo_max(lim_lo_max),
    .hi_min(lim_hi_min), .hi_max(lim_hi_max), .fault_avg(fault_avg), .raw(raw)
  );

  twc_persist #(.PERSIST_W(PERSIST_W)) u_pers (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .raw(raw),
    .persist_n(persist_n), .rsense_high(rsense_high), .variant_inv(variant_inv),
    .cls_out(cls_c), .state_out(logic_state), .stb_out(chg_stb)
  );

  assign cls_code = cls_c;

  a_r1_short_cause: assert property (@(posedge clk) disable iff (!rst_n)
    ((cls_c != $past(cls_c)) && (cls_c == CLS_SHORT)) |-> $past(smp_code > lim_hi_max));
  a_r3_gen_cause: assert property (@(posedge clk) disable iff (!rst_n)
    ((cls_c != $past(cls_c)) && (cls_c == CLS_GEN))
      |-> $past((smp_code > lim_lo_max) && (smp_code < lim_hi_min)));
  a_r5_sens_cause: assert property (@(posedge clk) disable iff (!rst_n)
    ((cls_c != $past(cls_c)) && (cls_c == CLS_SENS)) |-> $past(fault_avg && (smp_code < lim_hi_min)));
endmodule

// File: tb/tb_twc_level_classifier.sv
module tb_twc_level_classifier;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 8;
  localparam int PW = 3;
  localparam int ML = 6;
  localparam int SW = $clog2(ML + 1);

  logic clk = 1'b0;
  logic rst_n;
  logic smp_valid;
  logic [CW-1:0] smp_code, lo_min, lo_max, hi_min, hi_max, b_min, b_max;
  logic [SW-1:0] avg_log2;
  logic [PW-1:0] persist_n;
  logic rs_hi, v_inv;
  logic [2:0] cls_code;
  logic logic_state, chg_stb;

  int n_vec = 0, n_bad = 0;
  int m_acc, m_cnt, m_run;
  bit m_verd, m_state, m_stb;
  int m_pend, m_cls;

  always #(CLK_PERIOD/2) clk = ~clk;

  twc_level_classifier #(.CODE_W(CW), .PERSIST_W(PW), .MAX_AVG_LOG2(ML)) dut (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_code(smp_code),
    .lim_lo_min(lo_min), .lim_lo_max(lo_max), .lim_hi_min(hi_min), .lim_hi_max(hi_max),
    .band_min(b_min), .band_max(b_max), .avg_log2(avg_log2), .persist_n(persist_n),
    .rsense_high(rs_hi), .variant_inv(v_inv),
    .cls_code(cls_code), .logic_state(logic_state), .chg_stb(chg_stb)
  );

  function automatic string tag_of(int c);
    case (c)
      2: return "R1";
      0, 1: return "R2";
      4: return "R3";
      3: return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic chk(string tag, int act, int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  // Reference model: class codes 0 low,1 high,2 short,3 open,4 general,5 sensor fault
  function automatic int exp_raw(int c);
    if (c > hi_max) return 2;
    if (c >= hi_min) return 1;
    if (m_verd) return 5;
    if (c > lo_max) return 4;
    if (c >= lo_min) return 0;
    return 3;
  endfunction

  task automatic do_reset();
    smp_valid = 1'b0;
    smp_code  = '0;
    rst_n     = 1'b0;
    m_acc = 0; m_cnt = 0; m_verd = 0; m_pend = 3; m_run = 0;
    m_cls = 3; m_state = 0; m_stb = 0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9 class", int'(cls_code), 3);
    chk("R9 state", int'(logic_state), 0);
    chk("R9 strobe", int'(chg_stb), 0);
  endtask

  task automatic send(int c, string phase);
    int r, need, blk, ncls;
    bit nst;
    @(negedge clk);
    smp_valid = 1'b1;
    smp_code  = CW'(c);
    r = exp_raw(c);
    blk = 1 << avg_log2;
    m_acc += c; m_cnt++;
    if (m_cnt == blk) begin
      m_verd = ((m_acc / blk) >= b_min) && ((m_acc / blk) <= b_max);
      m_acc = 0; m_cnt = 0;
    end
    if (r == m_pend) m_run = (m_run < (1 << PW) - 1) ? m_run + 1 : m_run;
    else begin m_pend = r; m_run = 1; end
    need = (persist_n == 0) ? 1 : int'(persist_n);
    ncls = (m_run >= need) ? r : m_cls;
    nst = m_state;
    if (ncls == 1) nst = 1'b1 ^ rs_hi ^ v_inv;
    if (ncls == 0) nst = 1'b0 ^ rs_hi ^ v_inv;
    m_stb = (ncls != m_cls) || (nst != m_state);
    m_cls = ncls; m_state = nst;
    @(negedge clk);
    smp_valid = 1'b0;
    chk({tag_of(m_cls), " ", phase, " class"}, int'(cls_code), m_cls);
    chk({"R6 ", phase, " state"}, int'(logic_state), int'(m_state));
    chk({"R8 ", phase, " strobe"}, int'(chg_stb), int'(m_stb));
    @(negedge clk);
    chk({"R8 ", phase, " strobe drop"}, int'(chg_stb), 0);
    chk({"R10 ", phase, " idle class"}, int'(cls_code), m_cls);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    lo_min = 40; lo_max = 70; hi_min = 120; hi_max = 170;
    b_min = 5; b_max = 15; avg_log2 = 3; persist_n = 1;
    rs_hi = 0; v_inv = 0;
    do_reset();
    // Full ascending sweep for each polarity setting
    for (int p = 0; p < 4; p++) begin
      rs_hi = p[0]; v_inv = p[1];
      do_reset();
      for (int c = 0; c < 256; c++) send(c, "sweep");
      for (int c = 255; c >= 0; c -= 7) send(c, "down");
    end
    // R7 persistence with glitches, fault band disabled
    rs_hi = 0; v_inv = 0; avg_log2 = 0; b_min = 255; b_max = 0; persist_n = 3;
    do_reset();
    for (int k = 0; k < 4; k++) send(150, "R7");
    send(55, "R7"); send(150, "R7");
    send(55, "R7"); send(55, "R7"); send(150, "R7");
    for (int k = 0; k < 4; k++) send(55, "R7");
    send(200, "R7"); send(200, "R7"); send(90, "R7"); send(200, "R7");
    for (int k = 0; k < 9; k++) send(10, "R7");
    persist_n = 0;
    send(150, "R7 zero"); send(55, "R7 zero");
    // R5 sensor-fault signature: 32-sample period, one pulse per period
    persist_n = 1; avg_log2 = 5; b_min = 5; b_max = 15; lo_min = 20;
    do_reset();
    for (int p = 0; p < 4; p++)
      for (int k = 0; k < 32; k++) send((k == 17) ? 25 : 9, "R5 sig");
    send(130, "R5 high"); send(200, "R5 short");
    for (int k = 0; k < 30; k++) send(9, "R5 sig");
    for (int p = 0; p < 3; p++)
      for (int k = 0; k < 32; k++) send((k == 5) ? 25 : 2, "R5 clear");
    // avg_log2 = 0: each sample its own block
    avg_log2 = 0;
    do_reset();
    send(10, "R5 single"); send(10, "R5 single"); send(50, "R5 single");
    send(30, "R5 single"); send(60, "R5 single");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule